// File: doc/BRIEF.md
# Hot-Plug Slot Command Decoder

This block interprets byte-wide commands aimed at a row of hot-plug slots. Each command arrives as a one-cycle write strobe carrying an 8-bit code and a 5-bit target slot number. Numbering starts at 1, and target 0 is not a valid slot. Each slot keeps its own register, and the block updates it. That register holds a 2-bit slot state, a 2-bit power indicator, a 2-bit attention indicator, a latch-open flag, an empty flag and two sticky event bits, one for a latch change and one for a presence change. The block also keeps a small command status word, a secondary bus speed field and a command-detected flag. The flag is set whenever a command finishes.

Single-slot commands and bus speed commands complete on the clock edge that samples the write. The two bulk commands first confirm that no slot is enabled. They then visit one slot per clock while busy is high, and any write that arrives while busy is high is dropped. Power sequencing, device removal and interrupt delivery are left to neighbouring logic. That logic reads the outputs of this block and acknowledges the event bits and the detected flag.

Top module: `hpc_cmd_decoder`

## Requirements
- R1: While rst_n is low, a slot whose boot_present bit is 1 comes up enabled (state 2) with its power indicator on (1), latch closed and not empty. A slot whose bit is 0 comes up disabled (state 3) with its power indicator off (3), latch open and empty. Attention indicators, event bits, busy, all status bits, bus speed and cmd_detected reset to 0.
- R2: A code in 0x00..0x3F is a slot command. Bits [1:0] request a state: 0 keep, 1 power-only, 2 enabled, 3 disabled. Bits [3:2] give the power indicator and bits [5:4] the attention indicator: 0 keep, 1 on, 2 blink, 3 off. A nonzero indicator code is stored, and the result is visible after the edge that samples cmd_we.
- R3: A disabled slot moves to power-only or enabled on request. A power-only or enabled slot moves to disabled on request. Any other request leaves the state as it was.
- R4: A slot command whose target is 0 or above NUM_SLOTS sets sts_inv_cmd and changes no slot.
- R5: A request that takes an enabled slot to power-only sets sts_inv_cmd and changes neither the state nor the indicators of that slot.
- R6: Codes 0x40..0x47 select the bus speed from bits [2:0]. Speed 0 is stored, and any other value sets sts_inv_mode.
- R7: Every code outside 0x00..0x49 sets sts_inv_cmd.
- R8: Codes 0x48 (power-only all) and 0x49 (enable all) set sts_inv_cmd and change nothing when any slot is enabled. Busy never rises for a rejected bulk command.
- R9: An accepted bulk command raises sts_busy after the accepting edge. It then treats slot 0 up to slot NUM_SLOTS-1, one per edge. A slot with its latch closed is requested to power-only (0x48) or enabled (0x49) with its power indicator on. A slot with its latch open only has its power indicator set off. Busy falls on the edge that treats the last slot.
- R10: cmd_we is ignored while sts_busy is high.
- R11: A move to disabled while the resulting power indicator is off sets the latch-open and empty flags and both event bits. An evt_ack bit clears that slot's event bits, and a set in the same cycle wins over the clear.
- R12: Each accepted command clears the four status bits at its start and sets cmd_detected when it completes. det_clr clears cmd_detected, and a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_present | input | NUM_SLOTS | Slots occupied at reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code |
| cmd_target | input | 5 | Target slot number, 1-based |
| evt_ack | input | NUM_SLOTS | Clears the event bits of a slot |
| det_clr | input | 1 | Clears cmd_detected |
| slot_state | output | 2*NUM_SLOTS | Slot states, slot i at [2i+1:2i] |
| slot_pwr_ind | output | 2*NUM_SLOTS | Power indicators |
| slot_attn_ind | output | 2*NUM_SLOTS | Attention indicators |
| slot_mrl_open | output | NUM_SLOTS | Retention latch open |
| slot_empty | output | NUM_SLOTS | Slot reads empty |
| evt_mrl | output | NUM_SLOTS | Latched latch-change event |
| evt_presence | output | NUM_SLOTS | Latched presence-change event |
| bus_speed | output | 3 | Secondary bus speed |
| sts_busy | output | 1 | Bulk command in progress |
| sts_mrl_open | output | 1 | Latch-open command status |
| sts_inv_cmd | output | 1 | Invalid command status |
| sts_inv_mode | output | 1 | Invalid speed mode status |
| cmd_detected | output | 1 | Command completed flag |

## Verification
Single-slot, speed and rejected commands, as well as evt_ack and det_clr, take effect one edge after the falling edge that drives them. A bulk command shows busy one edge after it is accepted. Its final slot fields, the drop of busy and the detected flag are due NUM_SLOTS edges after that. The driver stamps every expected snapshot with the cycle on which it is due. The monitor compares the whole output vector on the falling edge of exactly that cycle, so no check samples while a register is still changing.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
   localparam int CODE_W    = 8;
   localparam int TGT_W     = 5;
   localparam int MAX_SLOTS = 31;

   localparam logic [1:0] ST_KEEP = 2'd0;
   localparam logic [1:0] ST_PWR  = 2'd1;
   localparam logic [1:0] ST_EN   = 2'd2;
   localparam logic [1:0] ST_DIS  = 2'd3;

   localparam logic [1:0] IND_KEEP = 2'd0;
   localparam logic [1:0] IND_ON   = 2'd1;
   localparam logic [1:0] IND_OFF  = 2'd3;

   localparam logic [CODE_W-1:0] OP_PWR_ALL = 8'h48;
   localparam logic [CODE_W-1:0] OP_EN_ALL  = 8'h49;

   typedef struct packed {
      logic [1:0] state;
      logic [1:0] pwr;
      logic [1:0] attn;
   } slot_req_t;
endpackage

// File: rtl/hpc_slot_cell.sv
module hpc_slot_cell
   import hpc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       boot_occ,
   input  logic       apply,
   input  slot_req_t  req,
   input  logic       evt_ack,
   output logic [1:0] state_q,
   output logic [1:0] pwr_q,
   output logic [1:0] attn_q,
   output logic       mrl_open_q,
   output logic       empty_q,
   output logic       evt_mrl_q,
   output logic       evt_prs_q
);
   logic [1:0] nxt_pwr;
   logic [1:0] nxt_attn;
   logic       go_up;
   logic       go_down;
   logic       eject;

   always_comb begin
      nxt_pwr  = (req.pwr  != IND_KEEP) ? req.pwr  : pwr_q;
      nxt_attn = (req.attn != IND_KEEP) ? req.attn : attn_q;
      go_up    = (state_q == ST_DIS) && ((req.state == ST_PWR) || (req.state == ST_EN));
      go_down  = ((state_q == ST_EN) || (state_q == ST_PWR)) && (req.state == ST_DIS);
      eject    = apply && go_down && (nxt_pwr == IND_OFF);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= boot_occ ? ST_EN : ST_DIS;
         pwr_q      <= boot_occ ? IND_ON : IND_OFF;
         attn_q     <= IND_KEEP;
         mrl_open_q <= !boot_occ;
         empty_q    <= !boot_occ;
         evt_mrl_q  <= 1'b0;
         evt_prs_q  <= 1'b0;
      end else begin
         if (apply) begin
            pwr_q  <= nxt_pwr;
            attn_q <= nxt_attn;
            if (go_up || go_down) state_q <= req.state;
         end
         if (eject) begin
            mrl_open_q <= 1'b1;
            empty_q    <= 1'b1;
         end
         evt_mrl_q <= eject | (evt_mrl_q & ~evt_ack);
         evt_prs_q <= eject | (evt_prs_q & ~evt_ack);
      end
   end
endmodule

// File: rtl/hpc_cmd_seq.sv
module hpc_cmd_seq
   import hpc_pkg::*;
#(
   parameter int NUM_SLOTS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_we,
   input  logic [CODE_W-1:0]      cmd_code,
   input  logic [TGT_W-1:0]       cmd_target,
   input  logic                   det_clr,
   input  logic [2*NUM_SLOTS-1:0] slot_state,
   input  logic [NUM_SLOTS-1:0]   slot_mrl_open,
   output logic [NUM_SLOTS-1:0]   apply,
   output slot_req_t              req,
   output logic [2:0]             bus_speed,
   output logic                   sts_busy,
   output logic                   sts_mrl_open,
   output logic                   sts_inv_cmd,
   output logic                   sts_inv_mode,
   output logic                   cmd_detected
);
   localparam int IDXW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
   localparam logic [IDXW-1:0] LAST = IDXW'(NUM_SLOTS - 1);

   logic [IDXW-1:0] idx_q;
   logic            bulk_en_q;
   logic [1:0]      sel_state;
   logic            cur_mrl;
   logic            any_en;
   logic            tgt_ok;
   logic            is_slot;
   logic            is_speed;
   logic            is_bulk;
   logic            en_to_pwr;
   logic            take;
   logic            slot_go;

   always_comb begin
      sel_state = ST_KEEP;
      cur_mrl   = 1'b0;
      any_en    = 1'b0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (cmd_target == TGT_W'(i + 1)) sel_state = slot_state[2*i +: 2];
         if (idx_q == IDXW'(i))           cur_mrl   = slot_mrl_open[i];
         if (slot_state[2*i +: 2] == ST_EN) any_en  = 1'b1;
      end
      tgt_ok    = (cmd_target != '0) && (int'(cmd_target) <= NUM_SLOTS);
      is_slot   = (cmd_code[7:6] == 2'b00);
      is_speed  = (cmd_code[7:3] == 5'b01000);
      is_bulk   = (cmd_code == OP_PWR_ALL) || (cmd_code == OP_EN_ALL);
      en_to_pwr = (sel_state == ST_EN) && (cmd_code[1:0] == ST_PWR);
      take      = cmd_we && !sts_busy;
      slot_go   = take && is_slot && tgt_ok && !en_to_pwr;
   end

   always_comb begin
      if (sts_busy) begin
         req.attn = IND_KEEP;
         if (cur_mrl) begin
            req.state = ST_KEEP;
            req.pwr   = IND_OFF;
         end else begin
            req.state = bulk_en_q ? ST_EN : ST_PWR;
            req.pwr   = IND_ON;
         end
      end else begin
         req.state = cmd_code[1:0];
         req.pwr   = cmd_code[3:2];
         req.attn  = cmd_code[5:4];
      end
      for (int i = 0; i < NUM_SLOTS; i++) begin
         apply[i] = sts_busy ? (idx_q == IDXW'(i))
                             : (slot_go && (cmd_target == TGT_W'(i + 1)));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q        <= '0;
         bulk_en_q    <= 1'b0;
         bus_speed    <= 3'd0;
         sts_busy     <= 1'b0;
         sts_mrl_open <= 1'b0;
         sts_inv_cmd  <= 1'b0;
         sts_inv_mode <= 1'b0;
         cmd_detected <= 1'b0;
      end else begin
         if (det_clr) cmd_detected <= 1'b0;
         if (sts_busy) begin
            if (idx_q == LAST) begin
               sts_busy     <= 1'b0;
               cmd_detected <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end else if (take) begin
            sts_mrl_open <= 1'b0;
            sts_inv_cmd  <= 1'b0;
            sts_inv_mode <= 1'b0;
            if (is_slot) begin
               if (!tgt_ok || en_to_pwr) sts_inv_cmd <= 1'b1;
               cmd_detected <= 1'b1;
            end else if (is_speed) begin
               if (cmd_code[2:0] != 3'd0) sts_inv_mode <= 1'b1;
               else                       bus_speed    <= cmd_code[2:0];
               cmd_detected <= 1'b1;
            end else if (is_bulk) begin
               if (any_en) begin
                  sts_inv_cmd  <= 1'b1;
                  cmd_detected <= 1'b1;
               end else begin
                  sts_busy  <= 1'b1;
                  idx_q     <= '0;
                  bulk_en_q <= cmd_code[0];
               end
            end else begin
               sts_inv_cmd  <= 1'b1;
               cmd_detected <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/hpc_cmd_decoder.sv
module hpc_cmd_decoder
   import hpc_pkg::*;
#(
   parameter int NUM_SLOTS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_SLOTS-1:0]   boot_present,
   input  logic                   cmd_we,
   input  logic [7:0]             cmd_code,
   input  logic [4:0]             cmd_target,
   input  logic [NUM_SLOTS-1:0]   evt_ack,
   input  logic                   det_clr,
   output logic [2*NUM_SLOTS-1:0] slot_state,
   output logic [2*NUM_SLOTS-1:0] slot_pwr_ind,
   output logic [2*NUM_SLOTS-1:0] slot_attn_ind,
   output logic [NUM_SLOTS-1:0]   slot_mrl_open,
   output logic [NUM_SLOTS-1:0]   slot_empty,
   output logic [NUM_SLOTS-1:0]   evt_mrl,
   output logic [NUM_SLOTS-1:0]   evt_presence,
   output logic [2:0]             bus_speed,
   output logic                   sts_busy,
   output logic                   sts_mrl_open,
   output logic                   sts_inv_cmd,
   output logic                   sts_inv_mode,
   output logic                   cmd_detected
);
   generate
      if (NUM_SLOTS < 1 || NUM_SLOTS > MAX_SLOTS) begin : g_bad_cfg
         $error("hpc_cmd_decoder: NUM_SLOTS must lie in 1..31");
      end
   endgenerate

   logic [NUM_SLOTS-1:0] apply;
   slot_req_t            req;

   hpc_cmd_seq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_we       (cmd_we),
      .cmd_code     (cmd_code),
      .cmd_target   (cmd_target),
      .det_clr      (det_clr),
      .slot_state   (slot_state),
      .slot_mrl_open(slot_mrl_open),
      .apply        (apply),
      .req          (req),
      .bus_speed    (bus_speed),
      .sts_busy     (sts_busy),
      .sts_mrl_open (sts_mrl_open),
      .sts_inv_cmd  (sts_inv_cmd),
      .sts_inv_mode (sts_inv_mode),
      .cmd_detected (cmd_detected)
   );

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         hpc_slot_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .boot_occ  (boot_present[s]),
            .apply     (apply[s]),
            .req       (req),
            .evt_ack   (evt_ack[s]),
            .state_q   (slot_state[2*s +: 2]),
            .pwr_q     (slot_pwr_ind[2*s +: 2]),
            .attn_q    (slot_attn_ind[2*s +: 2]),
            .mrl_open_q(slot_mrl_open[s]),
            .empty_q   (slot_empty[s]),
            .evt_mrl_q (evt_mrl[s]),
            .evt_prs_q (evt_presence[s])
         );
      end
   endgenerate
endmodule

// File: rtl/hpc_cmd_decoder_chk.sv
module hpc_cmd_decoder_chk #(
   parameter int NUM_SLOTS = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cmd_we,
   input logic [7:0]             cmd_code,
   input logic                   sts_busy,
   input logic                   sts_inv_cmd,
   input logic                   sts_inv_mode,
   input logic                   cmd_detected,
   input logic [2*NUM_SLOTS-1:0] slot_state,
   input logic [2*NUM_SLOTS-1:0] slot_attn_ind,
   input logic [NUM_SLOTS-1:0]   slot_mrl_open
);
   logic [7:0] busy_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !sts_busy) busy_cnt <= 8'd0;
      else                     busy_cnt <= busy_cnt + 8'd1;
   end

   // R12
   detect_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !sts_busy && cmd_code != 8'h48 && cmd_code != 8'h49) |=> cmd_detected);

   // R9
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= 8'(NUM_SLOTS));

   // R8
   busy_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts_busy |-> (!sts_inv_cmd && !sts_inv_mode));

   // R10
   busy_attn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts_busy |=> $stable(slot_attn_ind));

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_chk
         // R3
         state_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
            slot_state[2*s +: 2] != 2'b00);
         // R11
         mrl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            slot_mrl_open[s] |=> slot_mrl_open[s]);
      end
   endgenerate
endmodule

bind hpc_cmd_decoder hpc_cmd_decoder_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_we       (cmd_we),
   .cmd_code     (cmd_code),
   .sts_busy     (sts_busy),
   .sts_inv_cmd  (sts_inv_cmd),
   .sts_inv_mode (sts_inv_mode),
   .cmd_detected (cmd_detected),
   .slot_state   (slot_state),
   .slot_attn_ind(slot_attn_ind),
   .slot_mrl_open(slot_mrl_open)
);

// File: tb/hpc_cmd_decoder_test.sv
module hpc_cmd_decoder_test;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 4;
   localparam int W          = 10 * N + 8;
   localparam int WD_LIMIT   = 5000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   boot_present = 4'b0101;
   logic           cmd_we = 1'b0;
   logic [7:0]     cmd_code = 8'h00;
   logic [4:0]     cmd_target = 5'd0;
   logic [N-1:0]   evt_ack = '0;
   logic           det_clr = 1'b0;
   logic [2*N-1:0] slot_state, slot_pwr_ind, slot_attn_ind;
   logic [N-1:0]   slot_mrl_open, slot_empty, evt_mrl, evt_presence;
   logic [2:0]     bus_speed;
   logic           sts_busy, sts_mrl_open, sts_inv_cmd, sts_inv_mode, cmd_detected;

   always #(CLK_PERIOD / 2) clk = ~clk;

   hpc_cmd_decoder #(.NUM_SLOTS(N)) uut (
      .clk(clk), .rst_n(rst_n), .boot_present(boot_present), .cmd_we(cmd_we),
      .cmd_code(cmd_code), .cmd_target(cmd_target), .evt_ack(evt_ack), .det_clr(det_clr),
      .slot_state(slot_state), .slot_pwr_ind(slot_pwr_ind), .slot_attn_ind(slot_attn_ind),
      .slot_mrl_open(slot_mrl_open), .slot_empty(slot_empty), .evt_mrl(evt_mrl),
      .evt_presence(evt_presence), .bus_speed(bus_speed), .sts_busy(sts_busy),
      .sts_mrl_open(sts_mrl_open), .sts_inv_cmd(sts_inv_cmd), .sts_inv_mode(sts_inv_mode),
      .cmd_detected(cmd_detected)
   );

   // reference model, built from the requirements
   int m_st[N], m_pw[N], m_at[N];
   bit m_mrl[N], m_emp[N], m_em[N], m_ep[N];
   bit m_busy, m_mrls, m_ic, m_im, m_det;
   logic [2:0] m_spd;

   typedef struct {
      string          tag;
      int             due;
      logic [W-1:0]   exp;
   } item_t;
   item_t sbq[$];

   int cyc = 0;
   int n_tests = 0;
   int n_fail = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [W-1:0] snap_model();
      logic [W-1:0] v;
      for (int i = 0; i < N; i++)
         v[10*i +: 10] = {2'(m_st[i]), 2'(m_pw[i]), 2'(m_at[i]), m_mrl[i], m_emp[i], m_em[i], m_ep[i]};
      v[10*N +: 8] = {m_spd, m_busy, m_mrls, m_ic, m_im, m_det};
      return v;
   endfunction

   function automatic logic [W-1:0] snap_dut();
      logic [W-1:0] v;
      for (int i = 0; i < N; i++)
         v[10*i +: 10] = {slot_state[2*i +: 2], slot_pwr_ind[2*i +: 2], slot_attn_ind[2*i +: 2],
                          slot_mrl_open[i], slot_empty[i], evt_mrl[i], evt_presence[i]};
      v[10*N +: 8] = {bus_speed, sts_busy, sts_mrl_open, sts_inv_cmd, sts_inv_mode, cmd_detected};
      return v;
   endfunction

   function automatic void push(input string tag, input int due);
      item_t it;
      it.tag = tag;
      it.due = due;
      it.exp = snap_model();
      sbq.push_back(it);
   endfunction

   function automatic void m_slot(input int i, input int rs, input int rp, input int ra);
      int np, na;
      np = (rp != 0) ? rp : m_pw[i];
      na = (ra != 0) ? ra : m_at[i];
      m_pw[i] = np;
      m_at[i] = na;
      if (m_st[i] == 3 && (rs == 1 || rs == 2)) m_st[i] = rs;
      else if ((m_st[i] == 1 || m_st[i] == 2) && rs == 3) begin
         m_st[i] = 3;
         if (np == 3) begin
            m_mrl[i] = 1; m_emp[i] = 1; m_em[i] = 1; m_ep[i] = 1;
         end
      end
   endfunction

   function automatic void m_cmd(input logic [7:0] code, input int tgt);
      m_ic = 0; m_im = 0; m_mrls = 0; m_det = 1;
      if (code < 8'h40) begin
         if (tgt < 1 || tgt > N) m_ic = 1;
         else if (m_st[tgt-1] == 2 && code[1:0] == 2'd1) m_ic = 1;
         else m_slot(tgt - 1, code[1:0], code[3:2], code[5:4]);
      end else if (code < 8'h48) begin
         if (code[2:0] != 3'd0) m_im = 1;
         else m_spd = 3'd0;
      end else m_ic = 1;
   endfunction

   // monitor: compares each expectation on the falling edge of its due cycle
   always @(negedge clk) begin
      if (sbq.size() > 0 && sbq[0].due <= cyc) begin
         item_t it;
         logic [W-1:0] act;
         it = sbq.pop_front();
         act = snap_dut();
         n_tests++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   always @(posedge clk) begin
      if (cyc == WD_LIMIT) begin
         n_fail++;
         $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic send_cmd(input logic [7:0] code, input logic [4:0] tgt, input string tag);
      @(negedge clk);
      cmd_we = 1'b1; cmd_code = code; cmd_target = tgt;
      m_cmd(code, int'(tgt));
      push(tag, cyc + 1);
      @(negedge clk);
      cmd_we = 1'b0;
   endtask

   task automatic send_bulk(input logic [7:0] code, input logic [7:0] ign_code,
                            input logic [4:0] ign_tgt, input string tag);
      bit any_en;
      int k;
      @(negedge clk);
      cmd_we = 1'b1; cmd_code = code; cmd_target = 5'd0;
      m_ic = 0; m_im = 0; m_mrls = 0;
      any_en = 0;
      for (int i = 0; i < N; i++) if (m_st[i] == 2) any_en = 1;
      if (any_en) begin
         m_ic = 1; m_det = 1;
         push({tag, " rejected"}, cyc + 1);
         @(negedge clk);
         cmd_we = 1'b0;
         return;
      end
      m_busy = 1;
      k = cyc;
      push({tag, " busy"}, k + 1);
      @(negedge clk);
      cmd_code = ign_code; cmd_target = ign_tgt;   // R10: ignored while busy
      @(negedge clk);
      cmd_we = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (!m_mrl[i]) m_slot(i, code[0] ? 2 : 1, 1, 0);
         else           m_slot(i, 0, 3, 0);
      end
      m_busy = 0; m_det = 1;
      push({tag, " done"}, k + 1 + N);
      while (cyc < k + 1 + N) @(negedge clk);
   endtask

   task automatic pulse_ack(input logic [N-1:0] mask, input string tag);
      @(negedge clk);
      evt_ack = mask;
      for (int i = 0; i < N; i++) if (mask[i]) begin m_em[i] = 0; m_ep[i] = 0; end
      push(tag, cyc + 1);
      @(negedge clk);
      evt_ack = '0;
   endtask

   task automatic pulse_det_clr(input string tag);
      @(negedge clk);
      det_clr = 1'b1;
      m_det = 0;
      push(tag, cyc + 1);
      @(negedge clk);
      det_clr = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         m_st[i]  = boot_present[i] ? 2 : 3;
         m_pw[i]  = boot_present[i] ? 1 : 3;
         m_at[i]  = 0;
         m_mrl[i] = !boot_present[i];
         m_emp[i] = !boot_present[i];
         m_em[i]  = 0;
         m_ep[i]  = 0;
      end
      m_busy = 0; m_mrls = 0; m_ic = 0; m_im = 0; m_det = 0; m_spd = 3'd0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      push("R1 reset state", cyc + 1);
      @(negedge clk);

      send_cmd(8'h40, 5'd0, "R6 R12 speed 0 accepted");
      send_cmd(8'h43, 5'd0, "R6 speed 3 invalid mode");
      send_cmd(8'h02, 5'd0, "R4 R12 target zero");
      send_cmd(8'h02, 5'd5, "R4 target above count");
      send_cmd(8'h22, 5'd2, "R2 R3 disabled to enabled attn blink");
      send_cmd(8'h09, 5'd1, "R5 enabled to power-only refused");
      send_cmd(8'h0B, 5'd3, "R3 enabled to disabled pwr blink");
      send_cmd(8'h0F, 5'd1, "R11 disable with pwr off ejects");
      pulse_ack(4'b0001, "R11 event ack slot0");
      send_cmd(8'h80, 5'd1, "R7 unknown code 0x80");
      send_cmd(8'h4A, 5'd1, "R7 unknown code 0x4A");
      send_bulk(8'h49, 8'h00, 5'd0, "R8 enable-all with slot enabled");
      send_cmd(8'h03, 5'd2, "R11 disable slot1");
      pulse_det_clr("R12 detected clear");
      send_bulk(8'h48, 8'h30, 5'd3, "R9 R10 power-only all");
      send_bulk(8'h49, 8'h30, 5'd3, "R9 R3 enable-all on power-only slot");
      send_cmd(8'h03, 5'd3, "R3 power-only to disabled pwr on");
      send_bulk(8'h49, 8'h0F, 5'd3, "R9 R10 enable-all");
      send_bulk(8'h48, 8'h00, 5'd0, "R8 power-only all refused");

      wait (sbq.size() == 0);
      repeat (2) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule